// File: doc/BRIEF.md
# Byte-Multiplexed Conversion Result Readout

This block sits between a converter's sequencing logic and a host bus. It holds a 15-bit magnitude, a polarity flag and an overrange flag, and hands them out over an 8-bit bus with an output-enable for a three-state pad ring. The host selects the block with an active-high select and an active-low enable; the pair gates an active-low read strobe, which drives the bus, and an active-low write strobe, which asks the sequencer for a new conversion. Both the select and the strobes are sampled on the block clock.

In addressed (demand) mode the host chooses the byte with a byte-select input and, on the upper byte, chooses which flag occupies bit 7 with a flag-select input. In sequential (continuous) mode both selects are ignored: a three-step pointer, advanced each time a read ends, walks through upper byte with polarity, lower byte, upper byte with overrange. Captured data in sequential mode expires after a fixed number of clocks. In both modes the result is captured when the converter's busy signal falls and discarded when it rises again.

Top module: `rdx_readout_if`

## Requirements
- R1: The block is selected only when `cs` is 1 and `ce_n` is 0. `db_oe` is 1 exactly when selected with `rd_n` at 0, and `db_out` is all zeros whenever `db_oe` is 0; after reset both are 0 and `start_conv` is 0.
- R2: At the first clock edge at which `busy` is sampled 0 after having been sampled 1, the inputs `res_mag`, `res_pos` and `res_ovr` are captured; later changes of those inputs do not alter what is read.
- R3: In demand mode (`cont_mode` = 0), `byte_sel` = 0 drives the upper byte, with `res_mag[14:8]` on `db_out[6:0]` and a flag on `db_out[7]`; `byte_sel` = 1 drives `res_mag[7:0]`.
- R4: In demand mode on the upper byte, `flag_sel` = 1 places the overrange flag on `db_out[7]` (1 = over range) and `flag_sel` = 0 places the polarity flag there (1 = positive).
- R5: In continuous mode (`cont_mode` = 1), `byte_sel` and `flag_sel` have no effect; successive reads return the upper byte with polarity, then the lower byte, then the upper byte with overrange.
- R6: In continuous mode the byte pointer advances at the clock edge where a selected read ends (the selected-and-`rd_n`-low condition goes from 1 to 0); select may stay active throughout, and reads past the third byte return the third byte again.
- R7: Each capture returns the byte pointer to the first byte (upper with polarity).
- R8: In continuous mode, with `WINDOW` = W and capture at edge E, data reads as captured after edges E to E+W-1; at edge E+W the held result is cleared to zero and the pointer returns to the first byte.
- R9: In demand mode captured data does not expire; it remains readable until `busy` rises.
- R10: At the edge where `busy` is sampled 1 after 0, the held result is cleared in either mode, so reads return zeros.
- R11: `start_conv` is a one-clock pulse, registered one edge after the first clock at which `wr_n` is low while selected in demand mode; holding `wr_n` low gives no second pulse, and a write while unselected or in continuous mode gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Select, active high |
| ce_n | input | 1 | Enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Conversion request strobe, active low |
| cont_mode | input | 1 | 1 = continuous sequential readout, 0 = demand addressed readout |
| byte_sel | input | 1 | Demand mode: 1 = lower byte, 0 = upper byte |
| flag_sel | input | 1 | Demand mode upper byte bit 7: 1 = overrange, 0 = polarity |
| busy | input | 1 | Conversion in progress from the sequencer |
| res_mag | input | MAG_W (15) | Conversion magnitude |
| res_pos | input | 1 | Polarity, 1 = positive |
| res_ovr | input | 1 | Overrange, 1 = over range |
| db_out | output | BUS_W (8) | Bus data towards the pads |
| db_oe | output | 1 | Bus output enable for the three-state pads |
| start_conv | output | 1 | One-clock conversion request to the sequencer |

## Verification
Assertions watch the properties that hold at every edge: a capture always leaves valid data, a busy rise always empties the holder, valid data is only ever dropped in continuous mode or on a busy rise, the expiry counter never passes its limit, the pointer never leaves its three legal codes nor moves off the last one without a restart, and the start request is a single registered pulse caused by a selected demand-mode write. Only the bench's scenarios can show the actual byte contents under each select combination, the exact order of the sequential readout, that a new capture rewinds a half-read sequence, and the exact clock at which sequential data disappears; a behavioural reference model compares bus, enable and request on every clock.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

   // position of the sequential readout pointer; order is behaviour
   typedef enum logic [1:0] {
      SEQ_HI_POL = 2'd0,
      SEQ_LO     = 2'd1,
      SEQ_HI_OVR = 2'd2
   } seq_pos_e;

   localparam int unsigned SEQ_STEPS = 3;

endpackage

// File: rtl/rdx_edge_det.sv
module rdx_edge_det #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);

   logic lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse = lvl & ~lvl_q;
      end else begin : g_fall
         assign pulse = ~lvl & lvl_q;
      end
   endgenerate

endmodule

// File: rtl/rdx_result_hold.sv
module rdx_result_hold #(
   parameter int unsigned MAG_W     = 15,
   parameter int unsigned WINDOW    = 443,
   parameter bit          EXPIRE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             clear,
   input  logic             cont_mode,
   input  logic [MAG_W-1:0] mag_i,
   input  logic             pos_i,
   input  logic             ovr_i,
   output logic [MAG_W-1:0] mag_o,
   output logic             pos_o,
   output logic             ovr_o,
   output logic             valid_o,
   output logic             expire_o
);

   localparam int unsigned AGE_W = (WINDOW < 2) ? 1 : $clog2(WINDOW);

   generate
      if (WINDOW < 1) begin : g_bad_window
         $error("rdx_result_hold: WINDOW must be at least 1");
      end
      if (MAG_W < 2) begin : g_bad_mag
         $error("rdx_result_hold: MAG_W must be at least 2");
      end
   endgenerate

   // expiry timer, present only when the option is on
   generate
      if (EXPIRE_EN) begin : g_expiry
         logic [AGE_W-1:0] age_q;
         logic             at_limit;

         assign at_limit = (age_q == AGE_W'(WINDOW - 1));
         assign expire_o = cont_mode & valid_o & at_limit & ~load & ~clear;

         always_ff @(posedge clk) begin
            if (!rst_n)                         age_q <= '0;
            else if (load || clear || expire_o) age_q <= '0;
            else if (cont_mode && valid_o)      age_q <= age_q + 1'b1;
         end

         p_age_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
            age_q <= AGE_W'(WINDOW - 1))
            else $error("age counter passed its window");
      end else begin : g_no_expiry
         assign expire_o = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mag_o   <= '0;
         pos_o   <= 1'b0;
         ovr_o   <= 1'b0;
         valid_o <= 1'b0;
      end else if (load) begin
         mag_o   <= mag_i;
         pos_o   <= pos_i;
         ovr_o   <= ovr_i;
         valid_o <= 1'b1;
      end else if (clear || expire_o) begin
         mag_o   <= '0;
         pos_o   <= 1'b0;
         ovr_o   <= 1'b0;
         valid_o <= 1'b0;
      end
   end

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (valid_o && mag_o == $past(mag_i) && pos_o == $past(pos_i)))
      else $error("capture did not take the result");

   p_busy_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !load) |=> (!valid_o && mag_o == '0))
      else $error("busy rise left data behind");

endmodule

// File: rtl/rdx_byte_seq.sv
module rdx_byte_seq
   import rdx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     restart,
   input  logic     advance,
   output seq_pos_e idx
);

   always_ff @(posedge clk) begin
      if (!rst_n)       idx <= SEQ_HI_POL;
      else if (restart) idx <= SEQ_HI_POL;
      else if (advance) begin
         case (idx)
            SEQ_HI_POL: idx <= SEQ_LO;
            SEQ_LO:     idx <= SEQ_HI_OVR;
            default:    idx <= SEQ_HI_OVR;
         endcase
      end
   end

   p_seq_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      idx != seq_pos_e'(2'd3))
      else $error("pointer left its legal codes");

   p_seq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == SEQ_HI_OVR && !restart) |=> idx == SEQ_HI_OVR)
      else $error("pointer moved past the last byte");

   p_seq_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> idx == SEQ_HI_POL)
      else $error("restart did not rewind the pointer");

endmodule

// File: rtl/rdx_byte_mux.sv
module rdx_byte_mux
   import rdx_pkg::*;
#(
   parameter int unsigned BUS_W = 8,
   parameter int unsigned MAG_W = 15
) (
   input  logic             drive_en,
   input  logic             cont_mode,
   input  logic             byte_sel,
   input  logic             flag_sel,
   input  seq_pos_e         idx,
   input  logic [MAG_W-1:0] mag,
   input  logic             pos,
   input  logic             ovr,
   output logic [BUS_W-1:0] db
);

   logic             want_lo;
   logic             flag_bit;
   logic [BUS_W-1:0] hi_byte;
   logic [BUS_W-1:0] lo_byte;

   always_comb begin
      if (cont_mode) begin
         want_lo  = (idx == SEQ_LO);
         flag_bit = (idx == SEQ_HI_OVR) ? ovr : pos;
      end else begin
         want_lo  = byte_sel;
         flag_bit = flag_sel ? ovr : pos;
      end
   end

   // lanes: upper byte carries the flag on its top lane
   generate
      for (genvar b = 0; b < BUS_W; b++) begin : g_lane
         assign lo_byte[b] = mag[b];
         if (b == BUS_W - 1) begin : g_flag
            assign hi_byte[b] = flag_bit;
         end else begin : g_data
            assign hi_byte[b] = mag[BUS_W + b];
         end
         assign db[b] = drive_en & (want_lo ? lo_byte[b] : hi_byte[b]);
      end
   endgenerate

endmodule

// File: rtl/rdx_readout_if.sv
module rdx_readout_if
   import rdx_pkg::*;
#(
   parameter int unsigned BUS_W     = 8,
   parameter int unsigned MAG_W     = 2 * BUS_W - 1,
   parameter int unsigned WINDOW    = 443,
   parameter bit          EXPIRE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs,
   input  logic             ce_n,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic             cont_mode,
   input  logic             byte_sel,
   input  logic             flag_sel,
   input  logic             busy,
   input  logic [MAG_W-1:0] res_mag,
   input  logic             res_pos,
   input  logic             res_ovr,
   output logic [BUS_W-1:0] db_out,
   output logic             db_oe,
   output logic             start_conv
);

   generate
      if (BUS_W < 2) begin : g_bad_bus
         $error("rdx_readout_if: BUS_W must be at least 2");
      end
      if (MAG_W != 2 * BUS_W - 1) begin : g_bad_mag
         $error("rdx_readout_if: MAG_W must fill two bytes less one flag lane");
      end
   endgenerate

   logic             sel;
   logic             rd_act;
   logic             wr_act;
   logic             busy_fall;
   logic             busy_rise;
   logic             rd_end;
   logic             wr_begin;
   logic             expire;
   logic             held_valid;
   logic [MAG_W-1:0] held_mag;
   logic             held_pos;
   logic             held_ovr;
   seq_pos_e         idx;

   assign sel    = cs & ~ce_n;
   assign rd_act = sel & ~rd_n;
   assign wr_act = sel & ~wr_n & ~cont_mode;
   assign db_oe  = rd_act;

   rdx_edge_det #(.RISING(1'b0)) u_busy_fall (
      .clk(clk), .rst_n(rst_n), .lvl(busy), .pulse(busy_fall));

   rdx_edge_det #(.RISING(1'b1)) u_busy_rise (
      .clk(clk), .rst_n(rst_n), .lvl(busy), .pulse(busy_rise));

   rdx_edge_det #(.RISING(1'b0)) u_rd_end (
      .clk(clk), .rst_n(rst_n), .lvl(rd_act), .pulse(rd_end));

   rdx_edge_det #(.RISING(1'b1)) u_wr_begin (
      .clk(clk), .rst_n(rst_n), .lvl(wr_act), .pulse(wr_begin));

   rdx_result_hold #(
      .MAG_W(MAG_W), .WINDOW(WINDOW), .EXPIRE_EN(EXPIRE_EN)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (busy_fall),
      .clear    (busy_rise),
      .cont_mode(cont_mode),
      .mag_i    (res_mag),
      .pos_i    (res_pos),
      .ovr_i    (res_ovr),
      .mag_o    (held_mag),
      .pos_o    (held_pos),
      .ovr_o    (held_ovr),
      .valid_o  (held_valid),
      .expire_o (expire)
   );

   rdx_byte_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(busy_fall | busy_rise | expire),
      .advance(rd_end & cont_mode),
      .idx    (idx)
   );

   rdx_byte_mux #(.BUS_W(BUS_W), .MAG_W(MAG_W)) u_mux (
      .drive_en (rd_act),
      .cont_mode(cont_mode),
      .byte_sel (byte_sel),
      .flag_sel (flag_sel),
      .idx      (idx),
      .mag      (held_mag),
      .pos      (held_pos),
      .ovr      (held_ovr),
      .db       (db_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) start_conv <= 1'b0;
      else        start_conv <= wr_begin;
   end

   p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start_conv |=> !start_conv)
      else $error("conversion request wider than one clock");

   p_start_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start_conv |-> $past(cs && !ce_n && !wr_n && !cont_mode))
      else $error("conversion request without a selected demand write");

   p_demand_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(held_valid) |-> ($past(cont_mode) || $past(busy)))
      else $error("demand-mode data dropped without busy rising");

endmodule

// File: tb/tb_rdx_readout_if.sv
`timescale 1ns/1ps
module tb_rdx_readout_if;

   localparam int W = 443;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs, ce_n, rd_n, wr_n, cont_mode, byte_sel, flag_sel, busy;
   logic [14:0] res_mag;
   logic        res_pos, res_ovr;
   logic [7:0]  db_out;
   logic        db_oe, start_conv;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   rdx_readout_if #(.BUS_W(8), .WINDOW(W), .EXPIRE_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
      .cont_mode(cont_mode), .byte_sel(byte_sel), .flag_sel(flag_sel),
      .busy(busy), .res_mag(res_mag), .res_pos(res_pos), .res_ovr(res_ovr),
      .db_out(db_out), .db_oe(db_oe), .start_conv(start_conv));

   // behavioural reference model
   logic [14:0] m_mag;
   logic        m_pos, m_ovr, m_valid, m_start;
   int          m_idx, m_age;
   logic        busy_prev, rd_prev, wr_prev;

   always @(posedge clk) begin
      logic sel_now, rd_now, wr_now;
      sel_now = cs && !ce_n;
      rd_now  = sel_now && !rd_n;
      wr_now  = sel_now && !wr_n && !cont_mode;
      if (!rst_n) begin
         m_mag = 0; m_pos = 0; m_ovr = 0; m_valid = 0; m_start = 0;
         m_idx = 0; m_age = 0; busy_prev = 0; rd_prev = 0; wr_prev = 0;
      end else begin
         m_start = wr_now && !wr_prev;
         if (busy_prev && !busy) begin
            m_mag = res_mag; m_pos = res_pos; m_ovr = res_ovr;
            m_valid = 1; m_idx = 0; m_age = 0;
         end else if (!busy_prev && busy) begin
            m_mag = 0; m_pos = 0; m_ovr = 0; m_valid = 0; m_idx = 0; m_age = 0;
         end else begin
            if (cont_mode && rd_prev && !rd_now && m_idx < 2) m_idx++;
            if (cont_mode && m_valid) begin
               if (m_age == W - 1) begin
                  m_mag = 0; m_pos = 0; m_ovr = 0; m_valid = 0; m_idx = 0; m_age = 0;
               end else m_age++;
            end
         end
         busy_prev = busy; rd_prev = rd_now; wr_prev = wr_now;
      end
   end

   function automatic logic [7:0] model_bus();
      logic lo, flag;
      if (!(cs && !ce_n && !rd_n)) return 8'h00;
      if (cont_mode) begin
         lo   = (m_idx == 1);
         flag = (m_idx == 2) ? m_ovr : m_pos;
      end else begin
         lo   = byte_sel;
         flag = flag_sel ? m_ovr : m_pos;
      end
      return lo ? m_mag[7:0] : {flag, m_mag[14:8]};
   endfunction

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic exp_oe;
      exp_oe = cs && !ce_n && !rd_n;
      check8("R1 bus enable", {7'd0, db_oe}, {7'd0, exp_oe});
      check8(cont_mode ? "R5 bus data (model)" : "R3 bus data (model)", db_out, model_bus());
      check8("R11 start request (model)", {7'd0, start_conv}, {7'd0, m_start});
   endtask

   task automatic step();
      @(posedge clk);
      #5;
      compare();
   endtask

   task automatic read_byte(output logic [7:0] v);
      rd_n = 1'b0;
      #1 v = db_out;
      step();
      rd_n = 1'b1;
      step();
   endtask

   initial begin
      #4_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] v;
      rst_n = 0; cs = 0; ce_n = 1; rd_n = 1; wr_n = 1; cont_mode = 0;
      byte_sel = 0; flag_sel = 0; busy = 0; res_mag = '0; res_pos = 0; res_ovr = 0;
      repeat (3) @(posedge clk);
      #5 rst_n = 1;
      step();
      // R1: reset state
      check8("R1 reset oe", {7'd0, db_oe}, 8'h00);
      check8("R1 reset data", db_out, 8'h00);
      check8("R11 reset start", {7'd0, start_conv}, 8'h00);
      // R1: enable high deselects the read
      cs = 1; ce_n = 1; rd_n = 0; #1;
      check8("R1 enable blocks read", {7'd0, db_oe}, 8'h00);
      rd_n = 1; ce_n = 0; step();

      // R11: selected demand write
      wr_n = 0; step();
      check8("R11 start pulse", {7'd0, start_conv}, 8'h01);
      step();
      check8("R11 held write no repeat", {7'd0, start_conv}, 8'h00);
      wr_n = 1; cs = 0; step();
      wr_n = 0; step(); step();
      check8("R11 unselected write", {7'd0, start_conv}, 8'h00);
      wr_n = 1; cs = 1; cont_mode = 1; step();
      wr_n = 0; step(); step();
      check8("R11 continuous write", {7'd0, start_conv}, 8'h00);
      wr_n = 1; cont_mode = 0; step();

      // demand conversion: capture then change inputs
      res_mag = 15'h5A3C; res_pos = 1; res_ovr = 0;
      busy = 1; repeat (3) step();
      busy = 0; step();
      res_mag = 15'h0001; res_pos = 0; res_ovr = 1;
      byte_sel = 0; flag_sel = 0; read_byte(v);
      check8("R4 polarity on bit7 (R2 capture)", v, 8'hDA);
      flag_sel = 1; read_byte(v);
      check8("R4 overrange on bit7", v, 8'h5A);
      byte_sel = 1; read_byte(v);
      check8("R3 low byte", v, 8'h3C);
      byte_sel = 0; flag_sel = 0; read_byte(v);
      check8("R3 high byte again, any order", v, 8'hDA);
      repeat (W + 60) step();
      byte_sel = 1; read_byte(v);
      check8("R9 demand data kept", v, 8'h3C);
      busy = 1; step(); step();
      read_byte(v);
      check8("R10 cleared on busy rise", v, 8'h00);

      // continuous mode sequence with selects set to misleading values
      cont_mode = 1; byte_sel = 1; flag_sel = 1;
      res_mag = 15'h1281; res_pos = 0; res_ovr = 1;
      busy = 0; step();
      read_byte(v); check8("R5 first byte high+polarity", v, 8'h12);
      byte_sel = 0; flag_sel = 0;
      read_byte(v); check8("R5 second byte low", v, 8'h81);
      read_byte(v); check8("R5 third byte high+overrange", v, 8'h92);
      read_byte(v); check8("R6 fourth read repeats third", v, 8'h92);

      // R7: new capture rewinds a half-read sequence
      busy = 1; step(); busy = 0; step();
      read_byte(v); check8("R7 first after capture", v, 8'h12);
      read_byte(v); check8("R6 advance", v, 8'h81);
      busy = 1; step(); busy = 0; step();
      read_byte(v); check8("R7 rewind mid sequence", v, 8'h12);

      // R8: expiry window
      busy = 1; step(); busy = 0; step();
      for (int i = 1; i < W; i++) step();
      rd_n = 0; #1;
      check8("R8 last valid clock", db_out, 8'h12);
      step();
      check8("R8 expired to zero", db_out, 8'h00);
      rd_n = 1; step(); step();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule